// File: doc/BRIEF.md
# Memory error injection and capture unit

This block sits beside a 64-bit ECC memory datapath and gives software three things. It can corrupt outgoing write data and check bits on purpose, through XOR masks, so that the error paths can be exercised. It records the first failing access after single-bit or multi-bit errors are detected. It raises one interrupt line from sticky per-type flags. The ECC code and the DRAM protocol stay outside the block. Error strobes arrive as inputs, together with the data, check byte and address to capture.

Single-bit errors are counted first. They are reported only when a programmable threshold is reached. Status flags are cleared by writing ones to them. Detection can be masked per error type, and interrupts can be enabled per error type. All state is reached through a 32-bit register port: writes take effect at the clock edge and reads are combinational. The register offsets are word indices on `reg_addr`.

Register map: 0 data-mask upper, 1 data-mask lower, 2 injection control, 3 captured data upper, 4 captured data lower, 5 captured check byte, 6 captured address low, 7 captured address upper, 8 status, 9 detection mask, 10 interrupt enable, 11 single-bit management. Offsets 12 to 15 are unmapped.

Top module: `mem_err_unit`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and `wdat_out`/`wecc_out` equal `wdat_in`/`wecc_in`.
- R2: Injection control is offset 2, with bit 8 as the enable and bits 7:0 as the check-byte mask. While bit 8 is set, `wdat_out` = `wdat_in` XOR {offset 0, offset 1} and `wecc_out` = `wecc_in` XOR bits 7:0. While bit 8 is clear, both outputs pass through unchanged.
- R3: An `mbe_evt` pulse that is not masked sets status bit 1 (offset 8), which reads back at the next clock.
- R4: Each unmasked `sbe_evt` increments the counter in offset 11 bits 7:0. When the incremented value equals the threshold in bits 23:16, status bit 0 is set and the counter returns to 0. Writing 0x10000 therefore flags every single-bit error. The counter bits ignore writes.
- R5: While the threshold is 0, the counter is held at 0 and status bit 0 is never set by `sbe_evt`.
- R6: Writing a 1 to a status bit clears it, and a written 0 leaves it unchanged. An error that arrives in the same cycle as a clear keeps its bit set.
- R7: The capture registers (offsets 3 to 7) load `err_data`, `err_ecc` and `err_addr` only when a status bit is being set while all status bits are clear. Otherwise they hold their value, and they ignore register writes.
- R8: Detection mask offset 9 bit 0 blocks single-bit detection and counting, and bit 1 blocks multi-bit detection. Writing 0 enables both.
- R9: `irq` is high exactly when some status bit is set and its enable in offset 10 (bit 0 single, bit 1 multi) is set.
- R10: Offsets 12 to 15 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wdat_in | input | 64 | Write data from the datapath |
| wecc_in | input | 8 | Check byte from the datapath |
| wdat_out | output | 64 | Write data after injection |
| wecc_out | output | 8 | Check byte after injection |
| sbe_evt | input | 1 | Corrected single-bit error strobe |
| mbe_evt | input | 1 | Uncorrectable multi-bit error strobe |
| err_data | input | 64 | Data of the failing access |
| err_ecc | input | 8 | Received check byte of the failing access |
| err_addr | input | ADDR_W | Address of the failing access |
| irq | output | 1 | Error interrupt |

## Verification
A corrupted counter shows up as a status flag that appears one error too early or too late, and as a wrong value in the counter field at the next read. A capture register that reloads late shows up when a second error arrives: it overwrites the captured values one cycle after that error's strobe. A status bit that does not hold shows up on `irq` in the cycle after the lost bit. Injection errors show up immediately on `wdat_out` and `wecc_out`, because that path has no register.

// File: rtl/mem_err_unit.sv
module mem_err_unit #(
  parameter int ADDR_W = 40,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [63:0]       wdat_in,
  input  logic [7:0]        wecc_in,
  output logic [63:0]       wdat_out,
  output logic [7:0]        wecc_out,
  input  logic              sbe_evt,
  input  logic              mbe_evt,
  input  logic [63:0]       err_data,
  input  logic [7:0]        err_ecc,
  input  logic [ADDR_W-1:0] err_addr,
  output logic              irq
);
  localparam int XW = ADDR_W - 32;
  localparam logic [REG_AW-1:0] O_IHI = REG_AW'(0), O_ILO = REG_AW'(1), O_ICTL = REG_AW'(2),
    O_CHI = REG_AW'(3), O_CLO = REG_AW'(4), O_CECC = REG_AW'(5), O_CAL = REG_AW'(6),
    O_CAH = REG_AW'(7), O_DET = REG_AW'(8), O_DIS = REG_AW'(9), O_IEN = REG_AW'(10),
    O_MGT = REG_AW'(11);

  logic [31:0]       inj_hi, inj_lo;
  logic [8:0]        inj_ctl;
  logic [63:0]       cap_d;
  logic [7:0]        cap_e;
  logic [ADDR_W-1:0] cap_a;
  logic [1:0]        det, dis, ien;
  logic [7:0]        thr, cnt;

  wire         sbe_ok  = sbe_evt && !dis[0];
  wire         mbe_ok  = mbe_evt && !dis[1];
  wire [7:0]   cnt_inc = cnt + 8'd1;
  wire         sbe_hit = sbe_ok && (thr != 8'd0) && (cnt_inc == thr);
  wire [1:0]   set_v   = {mbe_ok, sbe_hit};
  wire [1:0]   clr_v   = (reg_wr && reg_addr == O_DET) ? reg_wdata[1:0] : 2'b00;
  wire         cap_ld  = (set_v != 2'b00) && (det == 2'b00);

  assign wdat_out = inj_ctl[8] ? (wdat_in ^ {inj_hi, inj_lo}) : wdat_in;
  assign wecc_out = inj_ctl[8] ? (wecc_in ^ inj_ctl[7:0]) : wecc_in;
  assign irq      = |(det & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_hi <= '0; inj_lo <= '0; inj_ctl <= '0;
      dis <= '0; ien <= '0; thr <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        O_IHI:  inj_hi  <= reg_wdata;
        O_ILO:  inj_lo  <= reg_wdata;
        O_ICTL: inj_ctl <= reg_wdata[8:0];
        O_DIS:  dis     <= reg_wdata[1:0];
        O_IEN:  ien     <= reg_wdata[1:0];
        O_MGT:  thr     <= reg_wdata[23:16];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det <= '0; cnt <= '0;
    end else begin
      det <= (det & ~clr_v) | set_v;
      if (thr == 8'd0)  cnt <= '0;
      else if (sbe_ok)  cnt <= sbe_hit ? 8'd0 : cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d <= '0; cap_e <= '0; cap_a <= '0;
    end else if (cap_ld) begin
      cap_d <= err_data; cap_e <= err_ecc; cap_a <= err_addr;
    end
  end

  always_comb begin
    case (reg_addr)
      O_IHI:  reg_rdata = inj_hi;
      O_ILO:  reg_rdata = inj_lo;
      O_ICTL: reg_rdata = {23'd0, inj_ctl};
      O_CHI:  reg_rdata = cap_d[63:32];
      O_CLO:  reg_rdata = cap_d[31:0];
      O_CECC: reg_rdata = {24'd0, cap_e};
      O_CAL:  reg_rdata = cap_a[31:0];
      O_CAH:  reg_rdata = {{(32-XW){1'b0}}, cap_a[ADDR_W-1:32]};
      O_DET:  reg_rdata = {30'd0, det};
      O_DIS:  reg_rdata = {30'd0, dis};
      O_IEN:  reg_rdata = {30'd0, ien};
      O_MGT:  reg_rdata = {8'd0, thr, 8'd0, cnt};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mem_err_unit_chk.sv
module mem_err_unit_chk #(
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mbe_evt,
  input logic              irq,
  input logic [63:0]       wdat_in,
  input logic [63:0]       wdat_out,
  input logic [8:0]        inj_ctl,
  input logic [1:0]        det,
  input logic [1:0]        dis,
  input logic [1:0]        ien,
  input logic [7:0]        thr,
  input logic [7:0]        cnt,
  input logic [63:0]       cap_d
);
  wire det_wr = reg_wr && (reg_addr == REG_AW'(8));

  // R3
  mbe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbe_evt && !dis[1]) |=> det[1]);

  // R6
  det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det[1] && !(det_wr && reg_wdata[1])) |=> det[1]);

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det != 2'b00) |=> $stable(cap_d));

  // R5
  thr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == 8'd0) |=> (cnt == 8'd0));

  // R8
  mbe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det[1] && dis[1]) |=> !det[1]);

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq);

  // R2
  inj_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_ctl[8] |-> (wdat_out == wdat_in));
endmodule

bind mem_err_unit mem_err_unit_chk #(.REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mbe_evt(mbe_evt), .irq(irq), .wdat_in(wdat_in),
  .wdat_out(wdat_out), .inj_ctl(inj_ctl), .det(det), .dis(dis), .ien(ien),
  .thr(thr), .cnt(cnt), .cap_d(cap_d)
);

// File: tb/mem_err_unit_tb.sv
module mem_err_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] wdat_in = 64'h0123_4567_89AB_CDEF;
  logic [7:0]  wecc_in = 8'h5A;
  logic [63:0] wdat_out;
  logic [7:0]  wecc_out;
  logic        sbe_evt = 1'b0, mbe_evt = 1'b0;
  logic [63:0] err_data = '0;
  logic [7:0]  err_ecc = '0;
  logic [39:0] err_addr = '0;
  logic        irq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  mem_err_unit dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, {32'd0, v}, {32'd0, exp});
  endtask

  task automatic err_pulse(input bit mbe, input logic [63:0] d, input logic [7:0] e, input logic [39:0] ad);
    @(negedge clk);
    sbe_evt = !mbe; mbe_evt = mbe; err_data = d; err_ecc = e; err_addr = ad;
    @(negedge clk);
    sbe_evt = 1'b0; mbe_evt = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) rchk("R1 reset reg", 4'(a), 32'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 data pass", wdat_out, wdat_in);
    chk("R1 ecc pass", {56'd0, wecc_out}, {56'd0, wecc_in});
  endtask

  task automatic t_inject;
    wr(4'd0, 32'hF000_0001); wr(4'd1, 32'h0000_0080); wr(4'd2, 32'h0A5);
    chk("R2 disabled data", wdat_out, wdat_in);
    chk("R2 disabled ecc", {56'd0, wecc_out}, {56'd0, wecc_in});
    wr(4'd2, 32'h1A5);
    #1;
    chk("R2 injected data", wdat_out, wdat_in ^ 64'hF000_0001_0000_0080);
    chk("R2 injected ecc", {56'd0, wecc_out}, {56'd0, wecc_in ^ 8'hA5});
    rchk("R2 ctl readback", 4'd2, 32'h1A5);
    wr(4'd2, 32'd0);
    #1;
    chk("R2 off again", wdat_out, wdat_in);
  endtask

  task automatic t_mbe;
    wr(4'd10, 32'd0);
    err_pulse(1'b1, 64'hDEAD_BEEF_CAFE_F00D, 8'h3C, 40'hAB_1234_5678);
    rchk("R3 mbe flag", 4'd8, 32'd2);
    rchk("R7 cap hi", 4'd3, 32'hDEAD_BEEF);
    rchk("R7 cap lo", 4'd4, 32'hCAFE_F00D);
    rchk("R7 cap ecc", 4'd5, 32'h3C);
    rchk("R7 cap addr lo", 4'd6, 32'h1234_5678);
    rchk("R7 cap addr hi", 4'd7, 32'hAB);
    chk("R9 irq not enabled", {63'd0, irq}, 64'd0);
    wr(4'd10, 32'd2);
    chk("R9 irq enabled", {63'd0, irq}, 64'd1);
    err_pulse(1'b1, 64'h1111_2222_3333_4444, 8'h77, 40'h01_0000_0000);
    rchk("R7 cap held", 4'd3, 32'hDEAD_BEEF);
    rchk("R7 cap ecc held", 4'd5, 32'h3C);
    wr(4'd3, 32'hFFFF_FFFF);
    rchk("R7 cap ignores write", 4'd3, 32'hDEAD_BEEF);
    wr(4'd8, 32'd1);
    rchk("R6 other bit kept", 4'd8, 32'd2);
    wr(4'd8, 32'd2);
    rchk("R6 cleared", 4'd8, 32'd0);
    chk("R9 irq dropped", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_sbe_thr;
    wr(4'd11, 32'h0003_00FF);
    rchk("R4 count not writable", 4'd11, 32'h0003_0000);
    err_pulse(1'b0, 64'h1, 8'h01, 40'h10);
    err_pulse(1'b0, 64'h2, 8'h02, 40'h20);
    rchk("R4 below threshold", 4'd8, 32'd0);
    rchk("R4 count two", 4'd11, 32'h0003_0002);
    err_pulse(1'b0, 64'h0000_0003_0000_0003, 8'h03, 40'h30);
    rchk("R4 threshold flag", 4'd8, 32'd1);
    rchk("R4 count wrapped", 4'd11, 32'h0003_0000);
    rchk("R7 sbe capture", 4'd3, 32'h3);
    rchk("R7 sbe capture addr", 4'd6, 32'h30);
    wr(4'd10, 32'd1);
    chk("R9 sbe irq", {63'd0, irq}, 64'd1);
    wr(4'd10, 32'd2);
    chk("R9 masked type", {63'd0, irq}, 64'd0);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd11, 32'h0001_0000);
    err_pulse(1'b0, 64'h5, 8'h05, 40'h50);
    rchk("R4 every error", 4'd8, 32'd1);
    wr(4'd8, 32'd1);
    rchk("R6 sbe cleared", 4'd8, 32'd0);
  endtask

  task automatic t_thr0;
    wr(4'd11, 32'd0);
    for (int i = 0; i < 3; i++) err_pulse(1'b0, 64'h9, 8'h09, 40'h90);
    rchk("R5 no flag", 4'd8, 32'd0);
    rchk("R5 count zero", 4'd11, 32'd0);
  endtask

  task automatic t_disable;
    wr(4'd11, 32'h0001_0000);
    wr(4'd9, 32'd3);
    err_pulse(1'b1, 64'hA, 8'h0A, 40'hA0);
    err_pulse(1'b0, 64'hB, 8'h0B, 40'hB0);
    rchk("R8 masked", 4'd8, 32'd0);
    rchk("R8 no capture", 4'd6, 32'h50);
    wr(4'd9, 32'd0);
    err_pulse(1'b0, 64'hC, 8'h0C, 40'hC0);
    rchk("R8 unmasked", 4'd8, 32'd1);
    wr(4'd8, 32'd3);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'd2; mbe_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; mbe_evt = 1'b0;
    rchk("R6 set beats clear", 4'd8, 32'd2);
    wr(4'd8, 32'd2);
  endtask

  task automatic t_unmapped;
    for (int a = 12; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    for (int a = 12; a < 16; a++) rchk("R10 unmapped zero", 4'(a), 32'd0);
    rchk("R10 inj hi intact", 4'd0, 32'hF000_0001);
    rchk("R10 mask intact", 4'd9, 32'd0);
    rchk("R10 ien intact", 4'd10, 32'd2);
    rchk("R10 mgmt intact", 4'd11, 32'h0001_0000);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_inject;
    t_mbe;
    t_sbe_thr;
    t_thr0;
    t_disable;
    t_set_wins;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule